// File: doc/BRIEF.md
# Host Command/Response Mailbox

This block is the device-side port of a small I/O-mapped mailbox that sits in front of a security coprocessor. A host reaches it through two byte addresses. Address 0 carries payload bytes in both directions. Address 1 returns a status byte on reads and takes a command code on writes. Inside the chip, accepted command bytes leave on a valid/ready stream toward a command consumer. Response bytes come in from a producer on a valid/ready stream that carries a last-byte flag.

A transfer is framed in-band. The host opens a command with a start code, streams bytes while the input-full flag is clear, and closes with an end code. The block then frames the response as a head marker, the payload bytes and a tail marker. Both markers are flagged by a dedicated status bit. An abort code is accepted in every state. It empties both buffers and returns the port to ready, so the host can issue the next command immediately.

Top module: `cmdrsp_mailbox`

## Requirements
- R1: After reset the status byte reads 0x10. Its bit positions are: bit0 output full, bit1 input full, bit2 marker flag, bit3 sticky drop error, bit4 ready for command, bit5 receiving data, bits 7..6 zero. No command byte is offered and no response byte is requested.
- R2: Writing 0x01 to address 1 while ready clears bit4 and sets bit5.
- R3: While receiving, a data write with input-full clear stores the byte, sets input-full and offers the byte on the command stream. The byte stays stable until it is accepted, and acceptance clears input-full. Bytes reach the consumer in write order.
- R4: A data write that arrives outside the receiving state, or while input-full is set, is discarded and sets the sticky error bit (bit3). The byte already held is not replaced.
- R5: Writing 0x03 while receiving ends the command. Once input-full is clear, a one-cycle end pulse goes to the consumer, and bits 5 and 4 both read 0 while the block waits for a response.
- R6: The first response byte offered starts the frame. The status then shows output-full and marker, and the data read returns 0x01. The producer byte is not consumed by this marker.
- R7: Each payload byte is shown with output-full set and marker clear. A data read clears output-full. The next byte is not loaded until that read, so no byte is lost.
- R8: After the byte flagged last has been read, the status shows output-full and marker, and the data read returns 0x03. That read returns the status to 0x10.
- R9: Writing 0x22 to address 1 in any state returns the status to 0x10 one cycle later. It drops any held byte in either direction, clears the error bit and raises a one-cycle abort pulse.
- R10: Command codes that do not apply in the current state, including unknown codes, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 1 | Host address: 0 data, 1 status/command |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (data reads have side effects) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the addressed register |
| cmd_valid | output | 1 | Command byte offered to the consumer |
| cmd_ready | input | 1 | Consumer accepts the offered byte |
| cmd_data | output | 8 | Command byte |
| cmd_end | output | 1 | One-cycle pulse: command complete |
| cmd_abort | output | 1 | One-cycle pulse: transfer aborted |
| rsp_valid | input | 1 | Producer offers a response byte |
| rsp_ready | output | 1 | Block takes the offered response byte |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Offered byte is the last of the response |

## Verification
The bench builds the block with its default code parameters: 0x01 to start, 0x03 to end and 0x22 to abort. With these values, a host model that polls the way a driver would can run full transactions unchanged. Random payloads and random consumer and producer stalls exercise the input-full backpressure and the one-byte output gate. Directed cases cover dropped writes, codes that do not apply, and aborts in the middle of a command and in the middle of a response, each followed by a back-to-back transaction. Each response carries its own length in big-endian form in bytes 2 to 5, and the bench decodes it from what the host actually read.

// File: rtl/cmdrsp_mailbox.sv
module cmdrsp_mailbox #(
  parameter logic [7:0] START_CODE = 8'h01,
  parameter logic [7:0] END_CODE   = 8'h03,
  parameter logic [7:0] ABORT_CODE = 8'h22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [7:0] cmd_data,
  output logic       cmd_end,
  output logic       cmd_abort,
  input  logic       rsp_valid,
  output logic       rsp_ready,
  input  logic [7:0] rsp_data,
  input  logic       rsp_last
);

  typedef enum logic [2:0] {
    S_IDLE, S_RECV, S_FLUSH, S_WAIT, S_BODY, S_TAIL, S_DONE
  } state_t;

  state_t     state;
  logic       ibf, obf, f0, err, abort_q;
  logic [7:0] ibuf, obuf;

  wire wr_data = host_wr && !host_addr;
  wire wr_cmd  = host_wr && host_addr;
  wire rd_data = host_rd && !host_addr;
  wire cancel  = wr_cmd && host_wdata == ABORT_CODE;
  wire start   = wr_cmd && host_wdata == START_CODE && state == S_IDLE;
  wire eoc     = wr_cmd && host_wdata == END_CODE && state == S_RECV;
  wire take    = wr_data && state == S_RECV && !ibf;
  wire drop    = wr_data && !take;
  wire consume = ibf && cmd_ready;
  wire rsp_hs  = rsp_valid && rsp_ready;

  wire [7:0] status = {2'b00, state == S_RECV, state == S_IDLE, err, f0, ibf, obf};

  assign host_rdata = host_addr ? status : obuf;
  assign cmd_valid  = ibf;
  assign cmd_data   = ibuf;
  assign cmd_end    = state == S_FLUSH && !ibf;
  assign cmd_abort  = abort_q;
  assign rsp_ready  = state == S_BODY && !obf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ibf     <= 1'b0;
      obf     <= 1'b0;
      f0      <= 1'b0;
      err     <= 1'b0;
      abort_q <= 1'b0;
      ibuf    <= 8'h00;
      obuf    <= 8'h00;
    end else begin
      abort_q <= cancel;
      if (cancel) begin
        state <= S_IDLE;
        ibf   <= 1'b0;
        obf   <= 1'b0;
        f0    <= 1'b0;
        err   <= 1'b0;
      end else begin
        if (take) begin
          ibuf <= host_wdata;
          ibf  <= 1'b1;
        end else if (consume) begin
          ibf <= 1'b0;
        end
        if (drop) err <= 1'b1;
        if (rd_data && obf) begin
          obf <= 1'b0;
          f0  <= 1'b0;
          if (state == S_DONE) state <= S_IDLE;
        end
        case (state)
          S_IDLE:  if (start) state <= S_RECV;
          S_RECV:  if (eoc) state <= S_FLUSH;
          S_FLUSH: if (!ibf) state <= S_WAIT;
          S_WAIT:
            if (rsp_valid) begin
              obuf  <= START_CODE;
              f0    <= 1'b1;
              obf   <= 1'b1;
              state <= S_BODY;
            end
          S_BODY:
            if (rsp_hs) begin
              obuf <= rsp_data;
              f0   <= 1'b0;
              obf  <= 1'b1;
              if (rsp_last) state <= S_TAIL;
            end
          S_TAIL:
            if (!obf) begin
              obuf  <= END_CODE;
              f0    <= 1'b1;
              obf   <= 1'b1;
              state <= S_DONE;
            end
          default: ;
        endcase
      end
    end
  end

  assert_start_recv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> state == S_RECV);

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !cancel |=> cmd_valid && $stable(cmd_data));

  assert_drop_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> err);

  assert_end_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end |=> !cmd_end && state == S_WAIT);

  assert_head_marker_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WAIT && rsp_valid && !cancel |=> obf && f0 && obuf == START_CODE);

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    obf && !rd_data && !cancel |=> obf && $stable(obuf));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && obf && !cancel |=> !obf);

  assert_cancel_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> state == S_IDLE && !ibf && !obf && !err && cmd_abort);

endmodule

// File: tb/cmdrsp_mailbox_tb.sv
module cmdrsp_mailbox_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       host_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       cmd_valid, cmd_end, cmd_abort, rsp_ready;
  logic       cmd_ready = 1'b0;
  logic [7:0] cmd_data;
  logic       rsp_valid = 1'b0, rsp_last = 1'b0;
  logic [7:0] rsp_data = 8'h00;

  cmdrsp_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_end(cmd_end), .cmd_abort(cmd_abort), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  int total = 0, bad = 0;
  int rx_n = 0, end_n = 0, abort_n = 0;
  logic [7:0] rx_mem [64];
  logic [7:0] tx_mem [64];
  logic [7:0] prod_mem [64];
  logic [7:0] got_mem [64];
  int prod_len = 0, prod_idx = 0;
  bit prod_en = 0, prod_fire = 0, cons_mode = 1;

  function automatic logic [7:0] stat(bit ibr, bit rdy, bit a2, bit f0, bit ibf, bit obf);
    return {2'b00, ibr, rdy, a2, f0, ibf, obf};
  endfunction

  function automatic int be32(logic [7:0] b2, logic [7:0] b3, logic [7:0] b4, logic [7:0] b5);
    return int'({b2, b3, b4, b5});
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (prod_fire) prod_idx++;
    rsp_valid = prod_en && prod_idx < prod_len && ($urandom % 4 != 0);
    rsp_data  = rsp_valid ? prod_mem[prod_idx] : 8'h00;
    rsp_last  = rsp_valid && prod_idx == prod_len - 1;
    prod_fire = rsp_valid && rsp_ready;
    cmd_ready = cons_mode ? ($urandom % 3 != 0) : 1'b0;
    if (cmd_valid && cmd_ready) begin
      rx_mem[rx_n % 64] = cmd_data;
      rx_n++;
    end
    if (cmd_end) end_n++;
    if (cmd_abort) abort_n++;
  end

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input bit a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic poll(input logic [7:0] mask, input logic [7:0] val, output logic [7:0] s);
    int g = 0;
    do begin
      rd(1'b1, s);
      g++;
    end while ((s & mask) != val && g < 2000);
    if (g >= 2000) chk("poll", int'(s & mask), int'(val));
  endtask

  task automatic do_abort();
    prod_en = 0;
    prod_idx = 0;
    prod_fire = 0;
    wr(1'b1, 8'h22);
  endtask

  task automatic txn(input int ncmd, input int nrsp);
    logic [7:0] s, d;
    int k;
    do_abort();
    rd(1'b1, s);
    chk("R9 abort->ready", s, 8'h10);
    wr(1'b1, 8'h01);
    rd(1'b1, s);
    chk("R2 start", s & 8'h30, 8'h20);
    rx_n = 0;
    for (int i = 0; i < ncmd; i++) begin
      poll(8'h02, 8'h00, s);
      tx_mem[i] = 8'($urandom);
      wr(1'b0, tx_mem[i]);
    end
    poll(8'h02, 8'h00, s);
    k = end_n;
    wr(1'b1, 8'h03);
    repeat (3) @(negedge clk);
    chk("R5 end pulse", end_n, k + 1);
    rd(1'b1, s);
    chk("R5 waiting status", s, 8'h00);
    chk("R3 byte count", rx_n, ncmd);
    for (int i = 0; i < ncmd; i++) chk("R3 byte order", rx_mem[i], tx_mem[i]);
    for (int i = 0; i < nrsp; i++) prod_mem[i] = 8'($urandom);
    {prod_mem[2], prod_mem[3], prod_mem[4], prod_mem[5]} = 32'(nrsp);
    prod_len = nrsp;
    prod_idx = 0;
    prod_en = 1;
    poll(8'h05, 8'h05, s);
    rd(1'b0, d);
    chk("R6 head marker", d, 8'h01);
    k = 0;
    forever begin
      poll(8'h01, 8'h01, s);
      if (s[2]) break;
      rd(1'b0, d);
      got_mem[k % 64] = d;
      chk("R7 payload", d, prod_mem[k % 64]);
      k++;
    end
    rd(1'b0, d);
    chk("R8 tail marker", d, 8'h03);
    chk("R8 payload count", k, nrsp);
    chk("R8 length field", be32(got_mem[2], got_mem[3], got_mem[4], got_mem[5]), nrsp);
    rd(1'b1, s);
    chk("R8 back to ready", s, 8'h10);
    prod_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    int a0;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(1'b1, s);
    chk("R1 reset status", s, stat(0, 1, 0, 0, 0, 0));
    chk("R1 no cmd valid", cmd_valid, 0);
    chk("R1 no rsp ready", rsp_ready, 0);

    wr(1'b0, 8'h55);
    rd(1'b1, s);
    chk("R4 drop in idle", s, stat(0, 1, 1, 0, 0, 0));
    chk("R4 nothing offered", cmd_valid, 0);
    do_abort();
    rd(1'b1, s);
    chk("R9 clears error", s, 8'h10);

    wr(1'b1, 8'h5A);
    rd(1'b1, s);
    chk("R10 unknown in idle", s, 8'h10);
    wr(1'b1, 8'h03);
    rd(1'b1, s);
    chk("R10 end in idle", s, 8'h10);

    cons_mode = 0;
    wr(1'b1, 8'h01);
    wr(1'b1, 8'h01);
    rd(1'b1, s);
    chk("R10 start while receiving", s, 8'h20);
    wr(1'b1, 8'h5A);
    rd(1'b1, s);
    chk("R10 unknown while receiving", s, 8'h20);
    wr(1'b0, 8'hAA);
    wr(1'b0, 8'hBB);
    rd(1'b1, s);
    chk("R4 drop while full", s, stat(1, 0, 1, 0, 1, 0));
    chk("R4 held byte kept", cmd_data, 8'hAA);
    rx_n = 0;
    cons_mode = 1;
    poll(8'h02, 8'h00, s);
    repeat (2) @(negedge clk);
    chk("R3 single delivery", rx_n, 1);
    chk("R3 delivered byte", rx_mem[0], 8'hAA);

    cons_mode = 0;
    do_abort();
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h77);
    a0 = abort_n;
    do_abort();
    @(negedge clk);
    chk("R9 abort pulse", abort_n, a0 + 1);
    chk("R9 command dropped", cmd_valid, 0);
    rd(1'b1, s);
    chk("R9 mid-command", s, 8'h10);
    cons_mode = 1;

    do_abort();
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h11);
    poll(8'h02, 8'h00, s);
    wr(1'b1, 8'h03);
    for (int i = 0; i < 8; i++) prod_mem[i] = 8'(i + 8'h40);
    prod_len = 8; prod_idx = 0; prod_en = 1;
    poll(8'h05, 8'h05, s);
    rd(1'b0, d);
    chk("R6 head before abort", d, 8'h01);
    poll(8'h01, 8'h01, s);
    rd(1'b0, d);
    chk("R7 first payload", d, 8'h40);
    do_abort();
    rd(1'b1, s);
    chk("R9 mid-response", s, 8'h10);
    chk("R9 no rsp ready", rsp_ready, 0);

    txn(3, 6);
    txn(1, 10);
    for (int t = 0; t < 15; t++) txn(1 + int'($urandom % 12), 6 + int'($urandom % 19));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule